// File: doc/BRIEF.md
# Two-Wire Serial Programming Target Interface

This block is the target end of a programming link made of a host-driven serial clock and one bidirectional data pin. Both pins are oversampled by the system clock through synchronisers, and their edges become single-cycle events. A command of six serial clock cycles is assembled from the data pin on falling edges, least significant bit first, and then decoded. Three commands (load configuration, load data and read data) are followed by a 16-cycle data frame. The other commands stand alone, so the serial cycle after them begins the next command.

Each decoded command goes out as a one-cycle pulse with the raw code and an operation number. A load frame delivers its 14-bit payload with a pulse at the end of the frame. A read command raises a request so that the address/memory controller can present the word. The block then shifts that word out on rising edges and drives an output-enable for the shared pin, which the pad logic uses to turn the pin around. A mode-enable input stands in for the high-voltage entry condition. While it is low, the block is held at the start of a new command.

Top module: `serprog_target`

## Requirements
- R1: Command bits are taken from the data pin on falling serial clock edges, first bit into `cmd_code[0]`. After the sixth falling edge, `cmd_valid` pulses for one system cycle and `cmd_code` holds all six bits.
- R2: `cmd_op` decodes `cmd_code` as follows: 0 for xx0000 (load configuration), 1 for xx0010 (load data), 2 for xx0100 (read), 3 for xx0110 (advance address), 4 for x11000 (start write), 5 for x01010 (stop write), 6 for xx1001 (erase all) and 7 for x10001 (erase row). Every other code gives 15. Bit 5 is always ignored, and so is bit 4 where the pattern shows x.
- R3: Don't-care bits never change `cmd_op`. Two codes that differ only in their x positions decode to the same value.
- R4: Only operations 0, 1 and 2 are followed by a 16-cycle frame. After any other code, including 15, the next six serial cycles form a new command.
- R5: In a load frame, the bits taken on falling edges 2 to 15 form `load_word`, LSb first. The values on falling edges 1 and 16 have no effect on it. `load_valid` pulses once after falling edge 16.
- R6: A read command pulses `rd_req` in the same cycle as its `cmd_valid`. `rd_word` is sampled at rising edge 2 of the frame that follows.
- R7: In a read frame, `sdat_oe` rises at rising edge 2 and falls after falling edge 16. At rising edge k (2 to 15), `sdat_out` carries bit k-2 of the word. At rising edge 16 it carries 0. Whenever `sdat_oe` is low, `sdat_out` is 0.
- R8: While `mode_en` is low, no pulse is issued and `sdat_oe` is low. Partly received commands or frames are dropped, and the first falling edge after `mode_en` returns is bit 0 of a new command.
- R9: A pin change is acted on at the third system clock edge after it. The serial clock must have at least four system cycles in each level.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Programming mode active; low holds the command start |
| sclk_pin | input | 1 | Serial clock from host (asynchronous) |
| sdat_pin | input | 1 | Data pin input path (asynchronous) |
| sdat_out | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output-enable |
| cmd_valid | output | 1 | One-cycle pulse: command decoded |
| cmd_code | output | 6 | Raw received command code |
| cmd_op | output | 4 | Decoded operation number |
| rd_req | output | 1 | One-cycle pulse: read word needed |
| rd_word | input | DATA_W | Word to send in the read frame |
| load_valid | output | 1 | One-cycle pulse: load payload complete |
| load_word | output | DATA_W | Received load payload |

## Verification
The assertions assume that the host holds each serial clock level for several system cycles. Under that assumption rising and falling events never coincide, and each frame boundary follows from a single falling event. They also assume that `rd_word` is steady from the read request until the second rising edge. The bench keeps within both assumptions. It changes pins only on the falling system clock and holds every serial level for four system cycles. It loads `rd_word` before it sends each read command and leaves it unchanged until the frame ends. The random command codes cover every don't-care pattern, and the `mode_en` drops are placed in the middle of commands and in the middle of read frames.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int CMD_BITS  = 6;
  localparam int WORD_BITS = 14;

  typedef enum logic [3:0] {
    OP_LOAD_CFG   = 4'd0,
    OP_LOAD_DATA  = 4'd1,
    OP_READ       = 4'd2,
    OP_INC_ADDR   = 4'd3,
    OP_PROG_BEGIN = 4'd4,
    OP_PROG_END   = 4'd5,
    OP_ERASE_ALL  = 4'd6,
    OP_ERASE_ROW  = 4'd7,
    OP_UNKNOWN    = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_LOAD = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  // Command decode; x positions are wildcards.
  function automatic op_e decode_cmd(input logic [CMD_BITS-1:0] code);
    op_e op;
    casez (code)
      6'b??0000: op = OP_LOAD_CFG;
      6'b??0010: op = OP_LOAD_DATA;
      6'b??0100: op = OP_READ;
      6'b??0110: op = OP_INC_ADDR;
      6'b?11000: op = OP_PROG_BEGIN;
      6'b?01010: op = OP_PROG_END;
      6'b??1001: op = OP_ERASE_ALL;
      6'b?10001: op = OP_ERASE_ROW;
      default:   op = OP_UNKNOWN;
    endcase
    return op;
  endfunction

  function automatic logic op_has_frame(input op_e op);
    return (op == OP_LOAD_CFG) || (op == OP_LOAD_DATA) || (op == OP_READ);
  endfunction

endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_clk,
  input  logic pin_dat,
  output logic dat_s,
  output logic rise_evt,
  output logic fall_evt
);
  logic [STAGES-1:0] c_pipe;
  logic [STAGES-1:0] d_pipe;
  logic              c_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_pipe <= '0;
          d_pipe <= '0;
        end else begin
          c_pipe <= pin_clk;
          d_pipe <= pin_dat;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_pipe <= '0;
          d_pipe <= '0;
        end else begin
          c_pipe <= {c_pipe[STAGES-2:0], pin_clk};
          d_pipe <= {d_pipe[STAGES-2:0], pin_dat};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_prev <= 1'b0;
    else        c_prev <= c_pipe[STAGES-1];
  end

  assign rise_evt = c_pipe[STAGES-1] & ~c_prev;
  assign fall_evt = ~c_pipe[STAGES-1] & c_prev;
  assign dat_s    = d_pipe[STAGES-1];
endmodule

// File: rtl/serprog_seq.sv
module serprog_seq
  import serprog_pkg::*;
#(
  parameter int DATA_W = WORD_BITS,
  parameter int CNT_W  = $clog2(DATA_W + 3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_en,
  input  logic                fall_evt,
  input  logic                dat_s,
  output phase_e              phase,
  output logic [CNT_W-1:0]    cnt,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_code,
  output op_e                 cmd_op,
  output logic                rd_req,
  output logic                load_valid,
  output logic [DATA_W-1:0]   load_word
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic [CMD_BITS-1:0] cmd_sr;
  logic [CMD_BITS-1:0] cmd_next;
  op_e                 op_next;
  logic                last_cmd_bit;
  logic                last_frame_bit;
  logic                payload_bit;

  assign cmd_next       = {dat_s, cmd_sr[CMD_BITS-1:1]};
  assign op_next        = decode_cmd(cmd_next);
  assign last_cmd_bit   = (cnt == CNT_W'(CMD_BITS - 1));
  assign last_frame_bit = (cnt == CNT_W'(FRAME_LEN - 1));
  assign payload_bit    = (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      cnt        <= '0;
      cmd_sr     <= '0;
      cmd_code   <= '0;
      cmd_op     <= OP_UNKNOWN;
      cmd_valid  <= 1'b0;
      rd_req     <= 1'b0;
      load_valid <= 1'b0;
      load_word  <= '0;
    end else begin
      cmd_valid  <= 1'b0;
      rd_req     <= 1'b0;
      load_valid <= 1'b0;
      if (!mode_en) begin
        phase <= PH_CMD;
        cnt   <= '0;
      end else if (fall_evt) begin
        if (phase == PH_CMD) begin
          cmd_sr <= cmd_next;
          if (last_cmd_bit) begin
            cnt       <= '0;
            cmd_valid <= 1'b1;
            cmd_code  <= cmd_next;
            cmd_op    <= op_next;
            rd_req    <= (op_next == OP_READ);
            if (op_has_frame(op_next))
              phase <= (op_next == OP_READ) ? PH_READ : PH_LOAD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else begin
          if (phase == PH_LOAD && payload_bit)
            load_word <= {dat_s, load_word[DATA_W-1:1]};
          if (last_frame_bit) begin
            cnt   <= '0;
            phase <= PH_CMD;
            if (phase == PH_LOAD) load_valid <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/serprog_rd_drv.sv
module serprog_rd_drv #(
  parameter int DATA_W = 14,
  parameter int CNT_W  = $clog2(DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              rd_phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] rd_word,
  output logic              sdat_out,
  output logic              sdat_oe
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      sdat_out <= 1'b0;
      sdat_oe  <= 1'b0;
    end else if (!mode_en) begin
      sdat_out <= 1'b0;
      sdat_oe  <= 1'b0;
    end else if (rd_phase && rise_evt) begin
      if (cnt == CNT_W'(1)) begin
        tx_sr    <= rd_word >> 1;
        sdat_out <= rd_word[0];
        sdat_oe  <= 1'b1;
      end else if (cnt >= CNT_W'(2) && cnt <= CNT_W'(DATA_W)) begin
        tx_sr    <= tx_sr >> 1;
        sdat_out <= tx_sr[0];
      end else if (cnt == CNT_W'(FRAME_LEN - 1)) begin
        sdat_out <= 1'b0;
      end
    end else if (rd_phase && fall_evt && cnt == CNT_W'(FRAME_LEN - 1)) begin
      sdat_out <= 1'b0;
      sdat_oe  <= 1'b0;
    end
  end
endmodule

// File: rtl/serprog_target.sv
module serprog_target
  import serprog_pkg::*;
#(
  parameter int DATA_W      = WORD_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_en,
  input  logic                sclk_pin,
  input  logic                sdat_pin,
  output logic                sdat_out,
  output logic                sdat_oe,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_code,
  output logic [3:0]          cmd_op,
  output logic                rd_req,
  input  logic [DATA_W-1:0]   rd_word,
  output logic                load_valid,
  output logic [DATA_W-1:0]   load_word
);
  localparam int CNT_W = $clog2(DATA_W + 3);

  logic             rise_evt;
  logic             fall_evt;
  logic             dat_s;
  phase_e           phase;
  logic [CNT_W-1:0] frame_cnt;
  op_e              op_q;
  logic             rd_phase;

  serprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_clk  (sclk_pin),
    .pin_dat  (sdat_pin),
    .dat_s    (dat_s),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  serprog_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_en    (mode_en),
    .fall_evt   (fall_evt),
    .dat_s      (dat_s),
    .phase      (phase),
    .cnt        (frame_cnt),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_op     (op_q),
    .rd_req     (rd_req),
    .load_valid (load_valid),
    .load_word  (load_word)
  );

  assign rd_phase = (phase == PH_READ);
  assign cmd_op   = op_q;

  serprog_rd_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .rd_phase (rd_phase),
    .cnt      (frame_cnt),
    .rd_word  (rd_word),
    .sdat_out (sdat_out),
    .sdat_oe  (sdat_oe)
  );
endmodule

// File: rtl/serprog_target_chk.sv
module serprog_target_chk
  import serprog_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       mode_en,
  input logic       rise_evt,
  input logic       fall_evt,
  input logic       sdat_out,
  input logic       sdat_oe,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       rd_req,
  input logic       load_valid
);
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!cmd_valid && !load_valid && !rd_req && !sdat_oe));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sdat_oe |-> !sdat_out);

  p_oe_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> $past(rise_evt));

  p_oe_off_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdat_oe) |-> ($past(fall_evt) || !$past(mode_en)));

  p_dout_moves_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdat_oe && $past(sdat_oe) && (sdat_out != $past(sdat_out))) |-> $past(rise_evt));

  p_rdreq_is_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cmd_valid && cmd_op == 4'(OP_READ)));

  p_cmd_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(fall_evt));

  p_load_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(fall_evt));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, load_valid}));
endmodule

bind serprog_target serprog_target_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_en    (mode_en),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .sdat_out   (sdat_out),
  .sdat_oe    (sdat_oe),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .rd_req     (rd_req),
  .load_valid (load_valid)
);

// File: tb/test_serprog_target.sv
module test_serprog_target;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_en = 1'b0;
  logic          sclk_pin = 1'b0;
  logic          sdat_pin = 1'b0;
  logic          sdat_out, sdat_oe;
  logic          cmd_valid, rd_req, load_valid;
  logic [5:0]    cmd_code;
  logic [3:0]    cmd_op;
  logic [DW-1:0] rd_word = '0;
  logic [DW-1:0] load_word;

  int n_chk = 0;
  int n_bad = 0;
  int n_cmd = 0;
  int n_load = 0;
  int n_rd = 0;
  logic [5:0]    seen_code;
  logic [3:0]    seen_op;
  logic [DW-1:0] seen_load;
  bit done = 0;

  always #10 clk = ~clk;

  serprog_target i_serprog_target (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .sclk_pin(sclk_pin), .sdat_pin(sdat_pin),
    .sdat_out(sdat_out), .sdat_oe(sdat_oe),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_op(cmd_op),
    .rd_req(rd_req), .rd_word(rd_word),
    .load_valid(load_valid), .load_word(load_word)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++;
      seen_code = cmd_code;
      seen_op = cmd_op;
    end
    if (load_valid) begin
      n_load++;
      seen_load = load_word;
    end
    if (rd_req) n_rd++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected decode restated from field values.
  function automatic int exp_op(input logic [5:0] c);
    int lo = int'(c[3:0]);
    if (lo == 0)  return 0;
    if (lo == 2)  return 1;
    if (lo == 4)  return 2;
    if (lo == 6)  return 3;
    if (lo == 9)  return 6;
    if (lo == 8  && c[4])  return 4;
    if (lo == 10 && !c[4]) return 5;
    if (lo == 1  && c[4])  return 7;
    return 15;
  endfunction

  task automatic ser_cycle(input bit d, output bit o, output bit e);
    @(negedge clk);
    sclk_pin = 1'b1;
    sdat_pin = d;
    repeat (4) @(negedge clk);
    o = sdat_out;
    e = sdat_oe;
    sclk_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    bit o, e;
    for (int i = 0; i < 6; i++) ser_cycle(c[i], o, e);
  endtask

  task automatic send_load(input logic [DW-1:0] w, input bit sb, input bit pb);
    bit o, e;
    ser_cycle(sb, o, e);
    for (int i = 0; i < DW; i++) ser_cycle(w[i], o, e);
    ser_cycle(pb, o, e);
  endtask

  task automatic recv_read(input logic [DW-1:0] w);
    bit o, e;
    int bad = 0;
    for (int k = 1; k <= DW + 2; k++) begin
      ser_cycle(1'b0, o, e);
      if (k == 1) begin
        if (e || o) bad++;
      end else if (k <= DW + 1) begin
        if (!e || o != w[k-2]) bad++;
      end else begin
        if (!e || o) bad++;
      end
    end
    chk("R7 read frame bit/oe errors", bad, 0);
    chk("R7 oe off after frame", int'(sdat_oe), 0);
    chk("R7 out low after frame", int'(sdat_out), 0);
  endtask

  task automatic run_cmd(input logic [5:0] c);
    int pc = n_cmd;
    int pr = n_rd;
    int pl = n_load;
    int op = exp_op(c);
    logic [DW-1:0] w = DW'($urandom);
    if (op == 2) rd_word = w;
    send_cmd(c);
    chk("R1 one cmd pulse", n_cmd - pc, 1);
    chk("R1 cmd code", int'(seen_code), int'(c));
    chk("R2 R3 cmd op", int'(seen_op), op);
    chk("R6 rd_req only for read", n_rd - pr, (op == 2) ? 1 : 0);
    if (op == 0 || op == 1) begin
      send_load(w, bit'($urandom), bit'($urandom));
      chk("R5 one load pulse", n_load - pl, 1);
      chk("R5 load word", int'(seen_load), int'(w));
    end else if (op == 2) begin
      recv_read(w);
      chk("R4 no load pulse on read", n_load - pl, 0);
    end else begin
      chk("R4 no frame, no load", n_load - pl, 0);
    end
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit o, e;
    int pc, pl;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset oe", int'(sdat_oe), 0);
    chk("R7 reset out", int'(sdat_out), 0);
    chk("R1 reset no cmd", n_cmd, 0);
    mode_en = 1'b1;
    repeat (4) @(negedge clk);

    // Directed: every code family, x bits varied (R2, R3).
    run_cmd(6'b000000);
    run_cmd(6'b110000);
    run_cmd(6'b010010);
    run_cmd(6'b100100);
    run_cmd(6'b000110);
    run_cmd(6'b011000);
    run_cmd(6'b111000);
    run_cmd(6'b001010);
    run_cmd(6'b101010);
    run_cmd(6'b011001);
    run_cmd(6'b110001);
    run_cmd(6'b001000);   // R4 unknown code, no frame
    run_cmd(6'b111111);

    // R4: non-framed command followed at once by a framed one.
    run_cmd(6'b000110);
    run_cmd(6'b000010);

    // Load with all ones payload and inverted start/stop (R5).
    pl = n_load;
    send_cmd(6'b000010);
    send_load({DW{1'b1}}, 1'b0, 1'b0);
    chk("R5 all ones payload", int'(seen_load), (1 << DW) - 1);
    send_cmd(6'b000010);
    send_load('0, 1'b1, 1'b1);
    chk("R5 zero payload, start/stop ignored", int'(seen_load), 0);
    chk("R5 two loads", n_load - pl, 2);

    // R8: drop mode_en mid command.
    pc = n_cmd;
    ser_cycle(1'b1, o, e);
    ser_cycle(1'b1, o, e);
    ser_cycle(1'b1, o, e);
    mode_en = 1'b0;
    repeat (6) @(negedge clk);
    mode_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no cmd from partial bits", n_cmd - pc, 0);
    run_cmd(6'b000110);

    // R8: drop mode_en mid read frame.
    rd_word = 14'h3fff;
    send_cmd(6'b000100);
    for (int k = 0; k < 5; k++) ser_cycle(1'b0, o, e);
    chk("R7 oe on mid read", int'(e), 1);
    mode_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 oe dropped", int'(sdat_oe), 0);
    chk("R8 out low", int'(sdat_out), 0);
    pc = n_cmd;
    ser_cycle(1'b0, o, e);
    ser_cycle(1'b1, o, e);
    chk("R8 ignored while off", n_cmd - pc, 0);
    chk("R8 oe stays off", int'(e), 0);
    mode_en = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(6'b000100);

    // Random commands (R1..R7, R9 timing margin throughout).
    for (int n = 0; n < 60; n++) run_cmd(6'($urandom));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule